// File: doc/BRIEF.md
# Twin-Predicated Element Mover

This block is a small sequencer that moves register-file elements from a source region to a destination region. A caller starts it with a vector length, two base indices, two predicate masks and a scalar/vector flag for each side. It then walks both regions and issues at most one read/write element pair per clock to a simple register-file port. The read port is asynchronous, and each written value is the word read in that same cycle.

The source and destination each have their own step counter. In twin mode each counter is steered by its own mask. The k-th enabled source element lands in the k-th enabled destination slot, so one engine covers compress, expand, compress-then-expand, splat, single-element insert and single-element extract. In single mode one mask governs both sides and the two steps move in lockstep.

The current steps stay visible on the ports at all times. Start takes initial step values, so an interrupted run can be resumed where it stopped. A one-cycle done pulse marks the end of every run.

Top module: `twin_pred_mover`

## Requirements
- R1: In twin mode with both sides vector, the k-th source index whose mask bit is 1 (ascending order) is read from `src_base + step` and written to `dst_base + step` of the k-th destination index whose mask bit is 1.
- R2: In twin mode every busy cycle handles one position per side. A side whose current mask bit is 0 advances by one without a write, and both sides may skip in the same cycle. A write happens only when both sides are enabled, and then both vector sides advance. There is at most one write per cycle.
- R3: When `pred_mode`=0 (single), only the source mask is used, for both sides, and `dst_mask` has no effect. Both steps start from `src_step_init` and advance together every busy cycle, staying equal. A write happens when the source mask bit at the common step is 1.
- R4: A side whose predicate-enable input is 0 behaves as if its mask were all ones.
- R5: In twin mode a scalar source (`src_vec`=0) is always enabled. Every write reads `src_base`, and the source step holds, so the one value is replicated into every enabled destination slot. A one-hot destination mask gives a single insert.
- R6: A scalar destination (`dst_vec`=0) receives only the first transferred element, at `dst_base`, and the run ends in that cycle. A one-hot source mask gives a single extract.
- R7: The run ends when either step reaches `vl` (0..MAXVL). Elements still pending on the other side are not written. With `vl`=0 there are no writes.
- R8: `start` is taken at a clock edge while idle, and `busy` is high from that edge. `wr_en`, `wr_addr` and `wr_data` are combinational in each busy cycle. The busy phase lasts one cycle per examined position. `done` is high for exactly one cycle, the cycle after the last busy cycle, when `busy` is already low.
- R9: `start` loads the steps from `src_step_init` and `dst_step_init`, which allows a resume. `src_step` and `dst_step` always show the live steps and hold their final values after the run.
- R10: After synchronous reset, `busy`, `done` and `wr_en` are 0 and both steps are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken while idle) |
| pred_mode | input | 1 | 1 = twin (independent masks), 0 = single (source mask for both) |
| vl | input | LEN_W | Vector length, 0..MAXVL |
| src_base | input | IDX_W | First source register index |
| dst_base | input | IDX_W | First destination register index |
| src_mask | input | MAXVL | Source predicate, bit i enables element i |
| dst_mask | input | MAXVL | Destination predicate, bit i enables slot i |
| src_pred_en | input | 1 | 0 = source mask treated as all ones |
| dst_pred_en | input | 1 | 0 = destination mask treated as all ones |
| src_vec | input | 1 | 1 = source is a vector, 0 = scalar |
| dst_vec | input | 1 | 1 = destination is a vector, 0 = scalar |
| src_step_init | input | LEN_W | Starting source step |
| dst_step_init | input | LEN_W | Starting destination step (twin mode) |
| rd_addr | output | IDX_W | Register-file read index |
| rd_data | input | DATA_W | Asynchronous read data for `rd_addr` |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | IDX_W | Register-file write index |
| wr_data | output | DATA_W | Register-file write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_step | output | LEN_W | Current source step |
| dst_step | output | LEN_W | Current destination step |

## Verification
The writes of a run are due in the busy cycles themselves. These are the cycles after the start edge, one per examined position, so the bench samples `wr_en`, `wr_addr` and `wr_data` at every falling edge while the run is active and collects them in order. `done` is due one edge after the last busy cycle. The bench counts falling edges from the start edge and requires `done` at exactly the count its own element-walk model predicts plus one. The final steps are read at that same falling edge, when the step registers have stopped moving.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    localparam int unsigned TPM_MAXVL_DEF  = 8;
    localparam int unsigned TPM_IDX_W_DEF  = 5;
    localparam int unsigned TPM_DATA_W_DEF = 16;

    typedef enum logic {
        PM_SINGLE = 1'b0,
        PM_TWIN   = 1'b1
    } pmode_e;

    // Per-side decision for one busy cycle
    typedef struct packed {
        logic ok;   // side enabled at current step
        logic adv;  // side step advances this cycle
    } side_act_t;

    // Decision for one side in twin mode
    function automatic side_act_t twin_side(input logic is_vec, input logic bit_en,
                                            input logic xfer, input logic live);
        side_act_t r;
        r.ok  = !is_vec || bit_en;
        r.adv = live && is_vec && (xfer || !r.ok);
        return r;
    endfunction

endpackage

// File: rtl/tpm_side.sv
module tpm_side #(
    parameter int unsigned MAXVL = 8,
    parameter int unsigned LEN_W = 4,
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] init_step,
    input  logic [IDX_W-1:0] base,
    input  logic             is_vec,
    input  logic             pred_en,
    input  logic [MAXVL-1:0] mask,
    input  logic             adv,
    output logic [LEN_W-1:0] step,
    output logic             vec_q,
    output logic             bit_en,
    output logic [IDX_W-1:0] addr
);
    logic [LEN_W-1:0] step_q;
    logic [IDX_W-1:0] base_q;
    logic [MAXVL-1:0] mask_q;
    logic [MAXVL-1:0] mask_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            base_q <= '0;
            mask_q <= '0;
            vec_q  <= 1'b0;
        end else if (load) begin
            step_q <= init_step;
            base_q <= base;
            mask_q <= pred_en ? mask : '1;
            vec_q  <= is_vec;
        end else if (adv) begin
            step_q <= step_q + LEN_W'(1);
        end
    end

    always_comb begin
        mask_sh = mask_q >> step_q;
        bit_en  = mask_sh[0];
        addr    = base_q + (vec_q ? IDX_W'(step_q) : '0);
        step    = step_q;
    end
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic fin,
    output logic busy,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= busy && fin;
            if (load)
                busy <= 1'b1;
            else if (fin)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover
    import tpm_pkg::*;
#(
    parameter int unsigned MAXVL  = TPM_MAXVL_DEF,
    parameter int unsigned IDX_W  = TPM_IDX_W_DEF,
    parameter int unsigned DATA_W = TPM_DATA_W_DEF,
    localparam int unsigned LEN_W = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pred_mode,
    input  logic [LEN_W-1:0]  vl,
    input  logic [IDX_W-1:0]  src_base,
    input  logic [IDX_W-1:0]  dst_base,
    input  logic [MAXVL-1:0]  src_mask,
    input  logic [MAXVL-1:0]  dst_mask,
    input  logic              src_pred_en,
    input  logic              dst_pred_en,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [LEN_W-1:0]  src_step_init,
    input  logic [LEN_W-1:0]  dst_step_init,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  src_step,
    output logic [LEN_W-1:0]  dst_step
);
    pmode_e           mode_q;
    logic [LEN_W-1:0] vl_q;
    logic             load, live, oor, xfer, fin;
    logic             s_bit, d_bit, s_vec, d_vec;
    side_act_t        s_act, d_act;
    logic [LEN_W-1:0] s_next, d_next, d_init;

    assign load   = start && !busy;
    assign d_init = (pred_mode == PM_TWIN) ? dst_step_init : src_step_init;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_SINGLE;
            vl_q   <= '0;
        end else if (load) begin
            mode_q <= pmode_e'(pred_mode);
            vl_q   <= vl;
        end
    end

    always_comb begin
        oor  = (src_step >= vl_q) || (dst_step >= vl_q);
        live = busy && !oor;
        if (mode_q == PM_TWIN) begin
            s_act = twin_side(s_vec, s_bit, 1'b0, 1'b0);
            d_act = twin_side(d_vec, d_bit, 1'b0, 1'b0);
            xfer  = live && s_act.ok && d_act.ok;
            s_act = twin_side(s_vec, s_bit, xfer, live);
            d_act = twin_side(d_vec, d_bit, xfer, live);
        end else begin
            xfer      = live && s_bit;
            s_act.ok  = s_bit;
            s_act.adv = live;
            d_act.ok  = s_bit;
            d_act.adv = live;
        end
        s_next = src_step + LEN_W'(s_act.adv);
        d_next = dst_step + LEN_W'(d_act.adv);
        fin    = busy && (oor || (xfer && !d_vec) || (s_next >= vl_q) || (d_next >= vl_q));
        wr_en   = xfer;
        wr_data = rd_data;
    end

    tpm_side #(.MAXVL(MAXVL), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_src (
        .clk(clk), .rst(rst), .load(load), .init_step(src_step_init),
        .base(src_base), .is_vec(src_vec), .pred_en(src_pred_en), .mask(src_mask),
        .adv(s_act.adv), .step(src_step), .vec_q(s_vec), .bit_en(s_bit), .addr(rd_addr)
    );

    tpm_side #(.MAXVL(MAXVL), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_dst (
        .clk(clk), .rst(rst), .load(load), .init_step(d_init),
        .base(dst_base), .is_vec(dst_vec), .pred_en(dst_pred_en), .mask(dst_mask),
        .adv(d_act.adv), .step(dst_step), .vec_q(d_vec), .bit_en(d_bit), .addr(wr_addr)
    );

    tpm_ctrl i_ctrl (
        .clk(clk), .rst(rst), .load(load), .fin(fin), .busy(busy), .done(done)
    );

    // R3: single mode keeps both steps equal
    a_r3_lockstep: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == PM_SINGLE) |-> (src_step == dst_step));

    // R6: a write to a scalar destination ends the run with a done pulse
    a_r6_scalar_dst_stop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !d_vec) |=> (!busy && done));

    // R8: done comes right after a busy cycle and only when idle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!busy && $past(busy)));

    // R1: every write to a vector destination moves the destination step by one
    a_r1_dst_advance: assert property (@(posedge clk) disable iff (rst)
        (wr_en && d_vec) |=> (dst_step == $past(dst_step) + LEN_W'(1)));

    // R2: no write while idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en);
endmodule

// File: tb/test_twin_pred_mover.sv
module test_twin_pred_mover;
    localparam int MAXVL = 8;
    localparam int IDX_W = 5;
    localparam int DATA_W = 16;
    localparam int LEN_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              pred_mode = 1'b1;
    logic [LEN_W-1:0]  vl = '0;
    logic [IDX_W-1:0]  src_base = '0, dst_base = '0;
    logic [MAXVL-1:0]  src_mask = '0, dst_mask = '0;
    logic              src_pred_en = 1'b0, dst_pred_en = 1'b0;
    logic              src_vec = 1'b1, dst_vec = 1'b1;
    logic [LEN_W-1:0]  src_step_init = '0, dst_step_init = '0;
    logic [IDX_W-1:0]  rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en, busy, done;
    logic [LEN_W-1:0]  src_step, dst_step;

    logic [DATA_W-1:0] mem [32];
    int n_checks = 0;
    int n_fail = 0;
    int cyc_total = 0;

    always #2 clk = ~clk;

    assign rd_data = mem[rd_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    twin_pred_mover i_twin_pred_mover (
        .clk(clk), .rst(rst), .start(start), .pred_mode(pred_mode), .vl(vl),
        .src_base(src_base), .dst_base(dst_base), .src_mask(src_mask), .dst_mask(dst_mask),
        .src_pred_en(src_pred_en), .dst_pred_en(dst_pred_en), .src_vec(src_vec), .dst_vec(dst_vec),
        .src_step_init(src_step_init), .dst_step_init(dst_step_init),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .src_step(src_step), .dst_step(dst_step)
    );

    function automatic logic [DATA_W-1:0] init_val(int i);
        return DATA_W'(16'h0100 + i * 3);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc_total);
            summary_and_end();
        end
    end

    task automatic run_case(string req, bit tw, bit sv, bit dv, bit spe, bit dpe,
                            logic [MAXVL-1:0] sm_in, logic [MAXVL-1:0] dm_in, int vln,
                            int sb, int db, int si, int di);
        int ea[16]; int ed[16]; int en = 0;
        int aa[16]; int ad[16]; int an = 0;
        int ss, ds, cyc, n;
        bit ok;
        logic [MAXVL-1:0] sm, dm;
        bit sok, dok, x, sa, da;
        // expected walk from the requirements
        sm = spe ? sm_in : '1;
        dm = (tw && dpe) ? dm_in : (tw ? '1 : sm);
        ss = si; ds = tw ? di : si; cyc = 0;
        forever begin
            cyc++;
            if (ss >= vln || ds >= vln) break;
            if (tw) begin
                sok = !sv || sm[ss]; dok = !dv || dm[ds];
                x = sok && dok; sa = sv && (x || !sok); da = dv && (x || !dok);
            end else begin
                x = sm[ss]; sa = 1'b1; da = 1'b1;
            end
            if (x) begin
                ea[en] = db + (dv ? ds : 0);
                ed[en] = int'(init_val(sb + (sv ? ss : 0)));
                en++;
            end
            ss += int'(sa); ds += int'(da);
            if ((x && !dv) || ss >= vln || ds >= vln) break;
        end
        for (int i = 0; i < 32; i++) mem[i] = init_val(i);
        @(negedge clk);
        pred_mode = tw; src_vec = sv; dst_vec = dv; src_pred_en = spe; dst_pred_en = dpe;
        src_mask = sm_in; dst_mask = dm_in; vl = LEN_W'(vln);
        src_base = IDX_W'(sb); dst_base = IDX_W'(db);
        src_step_init = LEN_W'(si); dst_step_init = LEN_W'(di);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            if (wr_en && an < 16) begin
                aa[an] = int'(wr_addr); ad[an] = int'(wr_data); an++;
            end
            @(negedge clk);
            n++;
        end
        ok = (an == en);
        for (int i = 0; i < 16; i++)
            if (i < en && i < an && (aa[i] != ea[i] || ad[i] != ed[i])) ok = 1'b0;
        check(ok, req, "write sequence (count)", an, en);
        check(done && n == cyc + 1, req, "R8 done cycle", n, cyc + 1);
        check(!busy, req, "R8 busy low at done", int'(busy), 0);
        check(int'(src_step) == ss && int'(dst_step) == ds, req, "R9 final steps",
              int'(src_step) * 100 + int'(dst_step), ss * 100 + ds);
    endtask

    initial begin
        logic [MAXVL-1:0] dset [8];
        dset = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h81, 8'h3C};
        for (int i = 0; i < 32; i++) mem[i] = init_val(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(!busy && !done && !wr_en, "R10", "idle outputs after reset",
              int'({busy, done, wr_en}), 0);
        check(src_step == 0 && dst_step == 0, "R10", "steps after reset",
              int'({src_step, dst_step}), 0);
        // R1 compress then expand
        run_case("R1", 1, 1, 1, 1, 1, 8'b1010_0110, 8'b0111_0001, 8, 0, 16, 0, 0);
        // R4 no predicate: plain copy
        run_case("R4", 1, 1, 1, 0, 0, 8'h00, 8'h00, 5, 2, 20, 0, 0);
        // R5 splat and single insert
        run_case("R5", 1, 0, 1, 1, 1, 8'h00, 8'b1001_0101, 8, 3, 16, 0, 0);
        run_case("R5", 1, 0, 1, 0, 1, 8'h00, 8'b0000_1000, 8, 5, 16, 0, 0);
        // R6 extract and scalar-to-scalar
        run_case("R6", 1, 1, 0, 1, 0, 8'b0001_0000, 8'h00, 8, 0, 20, 0, 0);
        run_case("R6", 1, 0, 0, 0, 0, 8'h00, 8'h00, 6, 4, 24, 0, 0);
        // R3 single mode, destination mask must not matter
        run_case("R3", 0, 1, 1, 1, 1, 8'b1100_1010, 8'h0F, 8, 0, 16, 0, 5);
        run_case("R3", 0, 1, 0, 1, 1, 8'b1100_1000, 8'hFF, 8, 0, 16, 0, 0);
        // R7 length limits
        run_case("R7", 1, 1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 16, 0, 0);
        run_case("R7", 1, 1, 1, 1, 1, 8'hFF, 8'b1000_0001, 8, 0, 16, 0, 0);
        run_case("R7", 1, 1, 1, 1, 1, 8'b0000_0110, 8'hFF, 3, 0, 16, 0, 0);
        // R9 resume from mid-run steps
        run_case("R9", 1, 1, 1, 1, 1, 8'b1010_0110, 8'b0111_0001, 8, 0, 16, 2, 1);
        // R2 sweep: every source mask against a set of destination masks
        for (int s = 0; s < 256; s++)
            for (int d = 0; d < 8; d++)
                run_case("R2", 1, 1, 1, 1, 1, MAXVL'(s), dset[d], 8, 0, 16, 0, 0);
        // R3 sweep over lengths in single mode
        for (int v = 0; v <= MAXVL; v++)
            run_case("R3", 0, 1, 1, 1, 0, 8'b0110_1101, 8'h00, v, 0, 16, 0, 0);
        summary_and_end();
    end
endmodule